// File: doc/BRIEF.md
# Serial Control Register Target for a Clock Fan-out Device

This block is the two-wire (SMBus) target that lets a host configure a multi-output clock distribution device. It keeps a small bank of 8-bit registers: enable bits for nineteen clock output pairs, a readback of the PLL operating mode and of the frequency-select strap, fixed identification bytes, and a byte-count register that sets the length a read reports. All of it is reached through indexed block transactions. Both bus lines are oversampled in the system clock domain. SDA is pulled low through an output-enable, and the target only takes part in bus traffic while the reference input clock is running.

The bus address is taken from two three-level straps. Each strap arrives as a code: 2'b00 is low, 2'b01 is mid, 2'b10 is high, and 2'b11 is treated as high. The straps and the frequency-select strap are latched on a power-good qualify pulse and are held after that. A write transaction carries a start index and a byte count, and the data bytes that follow land in consecutive registers. A read transaction first sets the index with a write header and then, after a repeated START, returns the count field followed by the register contents.

Top module: `smb_clkctl_regs`

## Requirements
- R1: The 8-bit write address is chosen by (strap_hi, strap_lo): (low,low)=D8, (low,mid)=DA, (low,high)=DE, (mid,low)=C2, (mid,mid)=C4, (mid,high)=C6, (high,low)=CA, (high,mid)=CC, (high,high)=CE (hex). The read address is the write address with bit 0 set. The target acknowledges its own address only.
- R2: The strap codes and freq_sel_100 are captured on a cycle where pwrgd_qual is 1 and are held unchanged otherwise. Reset values are low/low straps and frequency bit 1.
- R3: For an address that does not match, sda_oe stays 0 for the whole transaction and no register changes. sda_oe is 0 whenever the bus is idle.
- R4: A block write is START, write address, index N, count X, then data bytes, each byte acknowledged, then STOP. The data bytes land in registers N, N+1, ... in that order.
- R5: A block read is START, write address, index N, repeated START, read address. The target then sends the count byte, followed by the contents of register N, N+1, and so on, MSB first. It keeps sending while the host acknowledges, and after a host NACK it releases SDA.
- R6: Register 0 reads as {pll_mode[1:0], enables of outputs 18,17,16, 0, frequency bit, 0}. Only bits 5:3 are writable, and each of them resets to 1.
- R7: Registers 1 and 2 are writable enables for outputs 7..0 and 15..8, with bit 7 the highest output. They reset to FF. out_en[18:0] = {reg0[5:3], reg2, reg1}.
- R8: Register 7 bits 4:0 hold the count field. It resets to 8, is the first byte of every read, and bits 7:5 read 0.
- R9: Register 5 reads {rev_id, 4'hF}, register 6 reads 8'h82, and registers 3, 4 and 8 read 0. Writes to these registers are acknowledged and leave the contents unchanged.
- R10: The index advances by one after each data byte, and after register 8 it wraps to register 0.
- R11: While ref_clk_alive is 0, sda_oe stays 0 and no register is written.
- R12: In a write, data bytes beyond the count X are acknowledged and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_alive | input | 1 | Reference input clock is running |
| pwrgd_qual | input | 1 | Single-cycle pulse that latches the straps |
| strap_hi | input | 2 | First address strap level code |
| strap_lo | input | 2 | Second address strap level code |
| freq_sel_100 | input | 1 | Frequency strap, 1 = 100 MHz, 0 = 133 MHz |
| pll_mode | input | 2 | PLL operating mode for readback |
| rev_id | input | 4 | Revision identifier |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| out_en | output | 19 | Per-output enables, 0 forces a pair low/low |

## Verification
The bench targets the index wrap from register 8 to register 0 in both directions. A design without the wrap would write past the bank or return zeros instead of register 0. It also sends writes longer than their count, where an incorrect design would corrupt the following register. Writes to read-only bytes are checked as well, since a design that got them wrong would alter the identification or readback fields. The address table is walked across all nine strap settings together with a non-matching neighbour, and a strap change without a qualify pulse must not move the address. Reads with a rewritten count field show whether the first returned byte follows the register or is a fixed constant.

// File: rtl/smb_regs_pkg.sv
package smb_regs_pkg;
  localparam int unsigned NUM_OUT   = 19;
  localparam logic [7:0]  LAST_REG  = 8'd8;
  localparam logic [7:0]  DEVICE_ID = 8'h82;
  localparam logic [3:0]  VENDOR_ID = 4'hF;
  localparam logic [4:0]  COUNT_RST = 5'd8;
  localparam logic [7:0]  MASK_R0   = 8'h38;
  localparam logic [7:0]  MASK_R7   = 8'h1F;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_RACK
  } bus_st_e;

  typedef enum logic [1:0] {PH_INDEX, PH_COUNT, PH_DATA} wr_ph_e;

  function automatic logic [1:0] lvl_norm(input logic [1:0] c);
    return (c == 2'b11) ? 2'b10 : c;
  endfunction

  function automatic logic [6:0] strap_addr(input logic [1:0] hi, input logic [1:0] lo);
    logic [6:0] a;
    case ({lvl_norm(hi), lvl_norm(lo)})
      4'b0000: a = 7'h6C;
      4'b0001: a = 7'h6D;
      4'b0010: a = 7'h6F;
      4'b0100: a = 7'h61;
      4'b0101: a = 7'h62;
      4'b0110: a = 7'h63;
      4'b1000: a = 7'h65;
      4'b1001: a = 7'h66;
      default: a = 7'h67;
    endcase
    return a;
  endfunction

  function automatic logic [7:0] next_index(input logic [7:0] i);
    return (i >= LAST_REG) ? 8'd0 : i + 8'd1;
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      q_prev  <= '1;
    end else begin
      chain_q <= chain_n;
      q_prev  <= chain_q[STAGES-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/smb_strap_addr.sv
module smb_strap_addr
  import smb_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       qual,
  input  logic [1:0] sa_hi,
  input  logic [1:0] sa_lo,
  input  logic       freq_in,
  output logic [6:0] addr7,
  output logic       freq_q
);
  logic [1:0] hi_q, lo_q, hi_n, lo_n;
  logic       freq_n;

  always_comb begin
    hi_n   = hi_q;
    lo_n   = lo_q;
    freq_n = freq_q;
    if (qual) begin
      hi_n   = sa_hi;
      lo_n   = sa_lo;
      freq_n = freq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 2'b00;
      lo_q   <= 2'b00;
      freq_q <= 1'b1;
    end else begin
      hi_q   <= hi_n;
      lo_q   <= lo_n;
      freq_q <= freq_n;
    end
  end

  assign addr7 = strap_addr(hi_q, lo_q);

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> $stable(addr7));
  assert_freq_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> $stable(freq_q));
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_regs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         idx,
  input  logic [7:0]         wr_data,
  input  logic [1:0]         pll_mode,
  input  logic               freq_q,
  input  logic [3:0]         rev_id,
  output logic [7:0]         rd_data,
  output logic [NUM_OUT-1:0] out_en,
  output logic [4:0]         byte_count
);
  logic [7:0] r0_q, r1_q, r2_q, r7_q;
  logic [7:0] r0_n, r1_n, r2_n, r7_n;

  always_comb begin
    r0_n = r0_q;
    r1_n = r1_q;
    r2_n = r2_q;
    r7_n = r7_q;
    if (wr_en) begin
      case (idx)
        8'd0:    r0_n = wr_data & MASK_R0;
        8'd1:    r1_n = wr_data;
        8'd2:    r2_n = wr_data;
        8'd7:    r7_n = wr_data & MASK_R7;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0_q <= MASK_R0;
      r1_q <= 8'hFF;
      r2_q <= 8'hFF;
      r7_q <= {3'b000, COUNT_RST};
    end else begin
      r0_q <= r0_n;
      r1_q <= r1_n;
      r2_q <= r2_n;
      r7_q <= r7_n;
    end
  end

  always_comb begin
    case (idx)
      8'd0:    rd_data = {pll_mode, 6'b0} | r0_q | {6'b0, freq_q, 1'b0};
      8'd1:    rd_data = r1_q;
      8'd2:    rd_data = r2_q;
      8'd5:    rd_data = {rev_id, VENDOR_ID};
      8'd6:    rd_data = DEVICE_ID;
      8'd7:    rd_data = r7_q;
      default: rd_data = 8'h00;
    endcase
  end

  assign out_en     = {r0_q[5:3], r2_q, r1_q};
  assign byte_count = r7_q[4:0];

  assert_en_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(out_en));
  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(byte_count));
endmodule

// File: rtl/smb_clkctl_regs.sv
module smb_clkctl_regs
  import smb_regs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_clk_alive,
  input  logic               pwrgd_qual,
  input  logic [1:0]         strap_hi,
  input  logic [1:0]         strap_lo,
  input  logic               freq_sel_100,
  input  logic [1:0]         pll_mode,
  input  logic [3:0]         rev_id,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  output logic [NUM_OUT-1:0] out_en
);
  logic [1:0] line_s, line_p;
  logic scl_s, sda_s, scl_p, sda_p;
  logic scl_rise, scl_fall, bus_start, bus_stop;
  logic [6:0] my_addr7;
  logic freq_q;
  logic [7:0] rd_data;
  logic [4:0] byte_count;

  bus_st_e    st_q, st_n;
  wr_ph_e     ph_q, ph_n;
  logic [3:0] bit_q, bit_n;
  logic [7:0] rx_q, rx_n, tx_q, tx_n, ptr_q, ptr_n, left_q, left_n;
  logic       oe_q, oe_n, rw_q, rw_n, nack_q, nack_n;
  logic       wr_en;

  smb_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s), .q_prev(line_p));

  assign scl_s     = line_s[1];
  assign sda_s     = line_s[0];
  assign scl_p     = line_p[1];
  assign sda_p     = line_p[0];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

  smb_strap_addr u_strap (
    .clk(clk), .rst_n(rst_n), .qual(pwrgd_qual), .sa_hi(strap_hi), .sa_lo(strap_lo),
    .freq_in(freq_sel_100), .addr7(my_addr7), .freq_q(freq_q));

  smb_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(ptr_q), .wr_data(rx_q),
    .pll_mode(pll_mode), .freq_q(freq_q), .rev_id(rev_id), .rd_data(rd_data),
    .out_en(out_en), .byte_count(byte_count));

  always_comb begin
    st_n   = st_q;
    ph_n   = ph_q;
    bit_n  = bit_q;
    rx_n   = rx_q;
    tx_n   = tx_q;
    ptr_n  = ptr_q;
    left_n = left_q;
    oe_n   = oe_q;
    rw_n   = rw_q;
    nack_n = nack_q;
    wr_en  = 1'b0;
    if (!ref_clk_alive) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else if (bus_start) begin
      st_n  = ST_ADDR;
      bit_n = 4'd0;
      oe_n  = 1'b0;
    end else if (bus_stop) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_WBYTE: begin
          if (scl_rise) begin
            rx_n  = {rx_q[6:0], sda_s};
            bit_n = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (st_q == ST_ADDR) begin
              if (rx_q[7:1] == my_addr7) begin
                st_n = ST_ADDR_ACK;
                oe_n = 1'b1;
                rw_n = rx_q[0];
              end else begin
                st_n = ST_IDLE;
              end
            end else begin
              st_n = ST_WACK;
              oe_n = 1'b1;
              case (ph_q)
                PH_INDEX: begin
                  ptr_n = rx_q;
                  ph_n  = PH_COUNT;
                end
                PH_COUNT: begin
                  left_n = rx_q;
                  ph_n   = PH_DATA;
                end
                default: begin
                  if (left_q != 8'd0) begin
                    wr_en  = 1'b1;
                    ptr_n  = next_index(ptr_q);
                    left_n = left_q - 8'd1;
                  end
                end
              endcase
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_n = 4'd0;
            if (rw_q) begin
              tx_n = {3'b000, byte_count};
              oe_n = ~tx_n[7];
              st_n = ST_RBYTE;
            end else begin
              oe_n = 1'b0;
              ph_n = PH_INDEX;
              st_n = ST_WBYTE;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            bit_n = 4'd0;
            st_n  = ST_WBYTE;
          end
        end
        ST_RBYTE: begin
          if (scl_rise) begin
            bit_n = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_n = 1'b0;
              st_n = ST_RACK;
            end else begin
              tx_n = {tx_q[6:0], 1'b0};
              oe_n = ~tx_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack_n = sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              st_n = ST_IDLE;
            end else begin
              tx_n  = rd_data;
              oe_n  = ~rd_data[7];
              ptr_n = next_index(ptr_q);
              bit_n = 4'd0;
              st_n  = ST_RBYTE;
            end
          end
        end
        default: oe_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_INDEX;
      bit_q  <= 4'd0;
      rx_q   <= 8'd0;
      tx_q   <= 8'd0;
      ptr_q  <= 8'd0;
      left_q <= 8'd0;
      oe_q   <= 1'b0;
      rw_q   <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      bit_q  <= bit_n;
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      ptr_q  <= ptr_n;
      left_q <= left_n;
      oe_q   <= oe_n;
      rw_q   <= rw_n;
      nack_q <= nack_n;
    end
  end

  assign sda_oe = oe_q;

  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sda_oe);
  assert_drive_on_low_scl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  assert_quiet_without_ref_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_clk_alive |=> !sda_oe);
  assert_no_write_without_ref_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_clk_alive |-> !wr_en);
endmodule

// File: tb/tb_smb_clkctl_regs.sv
module tb_smb_clkctl_regs;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, ref_alive, qual, freq, scl_h, sda_h, sda_oe;
  logic [1:0]  shi, slo, pll;
  logic [3:0]  rev;
  logic [18:0] out_en;
  wire         sda_line = sda_h & ~sda_oe;

  smb_clkctl_regs dut (
    .clk(clk), .rst_n(rst_n), .ref_clk_alive(ref_alive), .pwrgd_qual(qual),
    .strap_hi(shi), .strap_lo(slo), .freq_sel_100(freq), .pll_mode(pll),
    .rev_id(rev), .scl_in(scl_h), .sda_in(sda_line), .sda_oe(sda_oe), .out_en(out_en));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [2:0] m_top;
  logic [7:0] m_lo, m_hi;
  logic [4:0] m_bc;
  logic       m_freq;
  logic [7:0] cur_a;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [12];
  logic [7:0] rcount;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_tab(input int i);
    case (i)
      0: return 8'hD8; 1: return 8'hDA; 2: return 8'hDE;
      3: return 8'hC2; 4: return 8'hC4; 5: return 8'hC6;
      6: return 8'hCA; 7: return 8'hCC; default: return 8'hCE;
    endcase
  endfunction

  function automatic logic [7:0] exp_reg(input int i);
    case (i)
      0: return {pll, m_top, 1'b0, m_freq, 1'b0};
      1: return m_lo;
      2: return m_hi;
      5: return {rev, 4'hF};
      6: return 8'h82;
      7: return {3'b000, m_bc};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(input int p, input logic [7:0] d);
    case (p)
      0: m_top = d[5:3];
      1: m_lo  = d;
      2: m_hi  = d;
      7: m_bc  = d[4:0];
      default: ;
    endcase
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_h = 1'b1; scl_h = 1'b1; wq();
    sda_h = 1'b0; wq();
    scl_h = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    sda_h = 1'b1; wq();
    scl_h = 1'b1; wq();
    sda_h = 1'b0; wq();
    scl_h = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wq();
    scl_h = 1'b1; wq();
    sda_h = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_h = b; wq();
    scl_h = 1'b1; wq(); wq();
    scl_h = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_h = 1'b1; wq();
    scl_h = 1'b1; wq();
    b = sda_line; wq();
    scl_h = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int k = 7; k >= 0; k--) put_bit(d[k]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    logic b;
    for (int k = 7; k >= 0; k--) begin
      get_bit(b);
      d[k] = b;
    end
    put_bit(nack);
  endtask

  task automatic block_write(input logic [7:0] a8, input logic [7:0] idx,
                             input logic [7:0] cnt, input int n, output bit all_ack);
    bit a;
    all_ack = 1'b1;
    bus_start();
    send_byte(a8, a); all_ack &= a;
    send_byte(idx, a); all_ack &= a;
    send_byte(cnt, a); all_ack &= a;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a);
      all_ack &= a;
    end
    bus_stop();
  endtask

  task automatic model_block(input int idx, input int cnt, input int n);
    int p = idx;
    for (int k = 0; k < n && k < cnt; k++) begin
      model_write(p, wbuf[k]);
      p = (p >= 8) ? 0 : p + 1;
    end
  endtask

  task automatic block_read(input logic [7:0] a8, input logic [7:0] idx,
                            input int n, output bit all_ack);
    bit a;
    all_ack = 1'b1;
    bus_start();
    send_byte(a8, a); all_ack &= a;
    send_byte(idx, a); all_ack &= a;
    bus_rstart();
    send_byte(a8 | 8'h01, a); all_ack &= a;
    recv_byte(n == 0, rcount);
    for (int k = 0; k < n; k++) recv_byte(k == n - 1, rbuf[k]);
    bus_stop();
  endtask

  task automatic probe(input logic [7:0] a8, output bit ack);
    bus_start();
    send_byte(a8, ack);
    bus_stop();
  endtask

  task automatic pulse_qual();
    @(negedge clk); qual = 1'b1;
    @(negedge clk); qual = 1'b0;
  endtask

  task automatic t_reset();
    check("R7 reset out_en", out_en, 19'h7FFFF);
    check("R3 reset sda_oe", sda_oe, 0);
  endtask

  task automatic t_default_read();
    bit ok;
    block_read(cur_a, 8'd0, 9, ok);
    check("R5 read acks", ok, 1);
    check("R8 count byte reset", rcount, 8);
    for (int i = 0; i < 9; i++) check($sformatf("R6/R9 reg%0d", i), rbuf[i], exp_reg(i));
  endtask

  task automatic t_block_write();
    bit ok;
    wbuf[0] = 8'hC7; wbuf[1] = 8'hA5; wbuf[2] = 8'h3C;
    block_write(cur_a, 8'd0, 8'd3, 3, ok);
    model_block(0, 3, 3);
    check("R4 write acks", ok, 1);
    repeat (4) @(negedge clk);
    check("R7 out_en map", out_en, {m_top, m_hi, m_lo});
    block_read(cur_a, 8'd0, 3, ok);
    check("R6 reg0 readback", rbuf[0], exp_reg(0));
    check("R4 reg1", rbuf[1], 8'hA5);
    check("R4 reg2", rbuf[2], 8'h3C);
  endtask

  task automatic t_count_limit();
    bit ok;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    block_write(cur_a, 8'd1, 8'd1, 2, ok);
    model_block(1, 1, 2);
    check("R12 extra byte acked", ok, 1);
    check("R12 out_en after limit", out_en, {m_top, m_hi, m_lo});
    check("R12 reg2 untouched", m_hi, 8'h3C);
  endtask

  task automatic t_readonly();
    bit ok;
    for (int k = 0; k < 4; k++) wbuf[k] = 8'h55;
    block_write(cur_a, 8'd3, 8'd4, 4, ok);
    check("R9 ro write acked", ok, 1);
    block_read(cur_a, 8'd3, 4, ok);
    for (int k = 0; k < 4; k++) check($sformatf("R9 reg%0d", k + 3), rbuf[k], exp_reg(k + 3));
  endtask

  task automatic t_wrap();
    bit ok;
    wbuf[0] = 8'hAA; wbuf[1] = 8'h28;
    block_write(cur_a, 8'd8, 8'd2, 2, ok);
    model_block(8, 2, 2);
    check("R10 wrap write acks", ok, 1);
    check("R10 wrap into reg0", out_en[18:16], 3'b101);
    block_read(cur_a, 8'd7, 3, ok);
    check("R10 read reg7", rbuf[0], exp_reg(7));
    check("R10 read reg8", rbuf[1], 8'h00);
    check("R10 read wrapped reg0", rbuf[2], exp_reg(0));
  endtask

  task automatic t_count_reg();
    bit ok;
    wbuf[0] = 8'hE5;
    block_write(cur_a, 8'd7, 8'd1, 1, ok);
    model_block(7, 1, 1);
    block_read(cur_a, 8'd7, 1, ok);
    check("R8 count byte follows reg7", rcount, 8'h05);
    check("R8 reserved bits zero", rbuf[0], 8'h05);
    wbuf[0] = 8'h08;
    block_write(cur_a, 8'd7, 8'd1, 1, ok);
    model_block(7, 1, 1);
  endtask

  task automatic t_addr_table();
    bit ok;
    for (int i = 0; i < 9; i++) begin
      shi = 2'(i / 3); slo = 2'(i % 3);
      pulse_qual();
      probe(addr_tab(i), ok);
      check($sformatf("R1 ack at %h", addr_tab(i)), ok, 1);
      probe(addr_tab((i + 1) % 9), ok);
      check($sformatf("R1 no ack at %h", addr_tab((i + 1) % 9)), ok, 0);
    end
    shi = 2'b11; slo = 2'b11;
    pulse_qual();
    probe(8'hCE, ok);
    check("R1 code 11 as high", ok, 1);
  endtask

  task automatic t_strap_hold();
    bit ok;
    shi = 2'b01; slo = 2'b10; freq = 1'b1;
    pulse_qual();
    cur_a = 8'hC6; m_freq = 1'b1;
    shi = 2'b00; slo = 2'b00; freq = 1'b0;
    repeat (5) @(negedge clk);
    probe(8'hC6, ok);
    check("R2 addr held", ok, 1);
    probe(8'hD8, ok);
    check("R2 new strap ignored", ok, 0);
    block_read(cur_a, 8'd0, 1, ok);
    check("R2 freq held", rbuf[0][1], 1);
    pulse_qual();
    cur_a = 8'hD8; m_freq = 1'b0;
    block_read(cur_a, 8'd0, 1, ok);
    check("R2 freq recaptured", rbuf[0], exp_reg(0));
  endtask

  task automatic t_nomatch();
    bit ok;
    wbuf[0] = 8'h00;
    block_write(8'hDA, 8'd1, 8'd1, 1, ok);
    check("R3 no ack for foreign addr", ok, 0);
    check("R3 regs unchanged", out_en, {m_top, m_hi, m_lo});
  endtask

  task automatic t_ref_dead();
    bit ok;
    ref_alive = 1'b0;
    wbuf[0] = 8'h00;
    block_write(cur_a, 8'd2, 8'd1, 1, ok);
    check("R11 silent without ref", ok, 0);
    check("R11 no write without ref", out_en, {m_top, m_hi, m_lo});
    ref_alive = 1'b1;
    probe(cur_a, ok);
    check("R11 back after ref", ok, 1);
  endtask

  initial begin
    rst_n = 1'b0; ref_alive = 1'b1; qual = 1'b0; freq = 1'b1;
    shi = 2'b00; slo = 2'b00; pll = 2'b10; rev = 4'h3;
    scl_h = 1'b1; sda_h = 1'b1;
    m_top = 3'b111; m_lo = 8'hFF; m_hi = 8'hFF; m_bc = 5'd8; m_freq = 1'b1;
    cur_a = 8'hD8;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_default_read();
    t_strap_hold();
    t_block_write();
    t_count_limit();
    t_readonly();
    t_wrap();
    t_count_reg();
    t_nomatch();
    t_ref_dead();
    t_addr_table();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule